// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Multicycle Execute

This block is a small in-order, single-issue integer pipeline with four stages: fetch, decode, execute and writeback. It runs a register-to-register instruction set of five operations (add, subtract, multiply, divide and store) over eight 16-bit registers. Programs sit in an internal instruction memory that is filled through a write port while the core is idle. Registers can be preloaded the same way. Store results land in an eight-entry data array that can be read back combinationally.

The execute latency depends on the opcode. Multiply and divide occupy execute for three cycles, and every other operation takes one. While execute is busy with a long operation, the fetch and decode stages hold their contents. Results are forwarded from execute back into decode. A dependent instruction therefore leaves decode at the end of its producer's final execute cycle, and never earlier.

A run begins with a start pulse and ends when the last instruction of the program retires. A retire strobe carries the index of each retiring instruction. A cycle counter measures the run and freezes when the done flag rises. Both load ports follow valid/ready rules. A write is taken on a clock edge where valid and ready are both high. Ready is held low for the whole of a run, so the port's owner must keep valid and the payload steady until ready returns.

Top module: `cpu4_pipe`

## Requirements
- R1: An instruction spends one cycle each in fetch, decode and writeback. With cycle 1 being the cycle after the start edge, a lone one-cycle instruction retires, with retire_valid high and retire_idx equal to its position, in cycle 4.
- R2: MUL and DIV stay in execute for 3 cycles, and all other opcodes for 1. While execute is busy, the younger instructions in decode and fetch hold.
- R3: A result is forwarded from execute into decode only in the producer's final execute cycle. A dependent instruction issues at the end of that cycle.
- R4: A value being written back in a given cycle is seen by an instruction that reads the same register in decode in that cycle.
- R5: When a register is written by several instructions, a reader gets the value of the most recent older writer.
- R6: Encoding: bits 15:13 opcode (0 ADD, 1 SUB, 2 MUL, 3 DIV, 4 STORE), bits 12:10 destination, bits 9:7 source A, bits 6:4 source B, bits 3:0 ignored. For STORE, the destination field is the data-array address and source A is the stored register.
- R7: Arithmetic wraps at 16 bits. MUL keeps the low 16 bits. DIV is unsigned and truncating, and divide by zero gives 0xFFFF.
- R8: STORE writes the data array in its execute cycle and does not write any register.
- R9: Opcodes 5 to 7 take one execute cycle, still retire, and write nothing.
- R10: A start pulse while idle runs instructions 0 to prog_len-1. In the cycle after the last one retires, done is high and cycle_count equals the index of the last retire cycle, and the count then stays frozen. A start pulse during a run is ignored.
- R11: prog_ready and rf_ready are low during a run, and a write offered while they are low is dropped.
- R12: After reset, all registers and data-array entries are 0, cycle_count is 0, and done and retire_valid are low.
- R13: The sequence ADD R5,R0,R1; MUL R6,R2,R5; SUB R5,R3,R6; DIV R6,R5,R4; STORE R6 computes (R3 - R2*(R0+R1))/R4 and retires its last instruction in cycle 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_valid | input | 1 | Instruction memory write offered |
| prog_ready | output | 1 | Instruction write accepted (idle) |
| prog_addr | input | 4 | Instruction memory address |
| prog_data | input | 16 | Instruction word |
| rf_valid | input | 1 | Register preload offered |
| rf_ready | output | 1 | Register preload accepted (idle) |
| rf_addr | input | 3 | Register to preload |
| rf_data | input | 16 | Preload value |
| start | input | 1 | Start pulse |
| prog_len | input | 5 | Number of instructions to run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| retire_valid | output | 1 | An instruction retires this cycle |
| retire_idx | output | 4 | Index of the retiring instruction |
| cycle_count | output | 16 | Cycles of the current or last run |
| dm_addr | input | 3 | Data array read address |
| dm_data | output | 16 | Data array read value |

## Verification
The bench builds the core with its default parameters: 16-bit data, a 16-entry program memory and three-cycle multiply and divide. With these values a whole dependence chain of long and short operations fits in one program, alongside distance-one and distance-two dependences and a register reuse chain. The reference model in the bench computes each instruction's stage cycles by recurrence and checks the retire strobe, index and count on every clock. It also interprets the program to predict the data array. A run with a start pulse and a preload offered mid-flight shows that both are dropped.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  localparam int INSTR_W  = 16;
  localparam int REG_AW   = 3;
  localparam int NREG     = 1 << REG_AW;
  localparam int DM_AW    = 3;
  localparam int DM_DEPTH = 1 << DM_AW;

  localparam logic [2:0] OPC_ADD   = 3'd0;
  localparam logic [2:0] OPC_SUB   = 3'd1;
  localparam logic [2:0] OPC_MUL   = 3'd2;
  localparam logic [2:0] OPC_DIV   = 3'd3;
  localparam logic [2:0] OPC_STORE = 3'd4;

  typedef struct packed {
    logic [2:0]        op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
  } dec_t;

  function automatic dec_t decode(input logic [INSTR_W-1:0] w);
    dec_t d;
    d.op = w[15:13];
    d.rd = w[12:10];
    d.ra = w[9:7];
    d.rb = w[6:4];
    return d;
  endfunction

  function automatic logic writes_reg(input logic [2:0] op);
    return op <= OPC_DIV;
  endfunction
endpackage

// File: rtl/cpu4_regfile.sv
module cpu4_regfile
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata[k] = mem[raddr[k]];
  end
endmodule

// File: rtl/cpu4_fwd_mux.sv
module cpu4_fwd_mux
  import cpu4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [REG_AW-1:0] src,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              ex_en,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [DATA_W-1:0] ex_val,
  input  logic              wb_en,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  // The youngest older producer wins: execute, then writeback, then the file.
  always_comb begin
    if (ex_en && ex_rd == src)      opnd = ex_val;
    else if (wb_en && wb_rd == src) opnd = wb_val;
    else                            opnd = rf_val;
  end
endmodule

// File: rtl/cpu4_exec.sv
module cpu4_exec
  import cpu4_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MUL_LAT = 3,
  parameter int DIV_LAT = 3,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [2:0]        op_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              done_o,
  output logic              free_o,
  output logic [2:0]        op_o,
  output logic [REG_AW-1:0] rd_o,
  output logic [DATA_W-1:0] res_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic              v_q;
  logic [2:0]        op_q;
  logic [REG_AW-1:0] rd_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LAT_W-1:0]  cnt_q, last_cnt;

  always_comb begin
    case (op_q)
      OPC_MUL: last_cnt = LAT_W'(MUL_LAT - 1);
      OPC_DIV: last_cnt = LAT_W'(DIV_LAT - 1);
      default: last_cnt = '0;
    endcase
  end

  assign done_o = v_q && (cnt_q == last_cnt);
  assign free_o = !v_q || done_o;

  always_comb begin
    case (op_q)
      OPC_ADD:   res_o = a_q + b_q;
      OPC_SUB:   res_o = a_q - b_q;
      OPC_MUL:   res_o = a_q * b_q;
      OPC_DIV:   res_o = (b_q == '0) ? '1 : a_q / b_q;
      OPC_STORE: res_o = a_q;
      default:   res_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      op_q  <= '0;
      rd_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (free_o) begin
      v_q <= issue_i;
      if (issue_i) begin
        op_q  <= op_i;
        rd_q  <= rd_i;
        a_q   <= a_i;
        b_q   <= b_i;
        idx_q <= idx_i;
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = v_q;
  assign op_o    = op_q;
  assign rd_o    = rd_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/cpu4_pipe.sv
module cpu4_pipe
  import cpu4_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IMEM_DEPTH = 16,
  parameter int MUL_LAT    = 3,
  parameter int DIV_LAT    = 3,
  parameter int CNT_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_valid,
  output logic                        prog_ready,
  input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr,
  input  logic [INSTR_W-1:0]          prog_data,
  input  logic                        rf_valid,
  output logic                        rf_ready,
  input  logic [REG_AW-1:0]           rf_addr,
  input  logic [DATA_W-1:0]           rf_data,
  input  logic                        start,
  input  logic [$clog2(IMEM_DEPTH):0] prog_len,
  output logic                        busy,
  output logic                        done,
  output logic                        retire_valid,
  output logic [$clog2(IMEM_DEPTH)-1:0] retire_idx,
  output logic [CNT_W-1:0]            cycle_count,
  input  logic [DM_AW-1:0]            dm_addr,
  output logic [DATA_W-1:0]           dm_data
);
  localparam int IMEM_AW = $clog2(IMEM_DEPTH);
  localparam int LEN_W   = IMEM_AW + 1;

  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [DATA_W-1:0]  dmem [DM_DEPTH];

  logic               busy_q, done_q;
  logic [LEN_W-1:0]   len_q, pc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               f_valid, id_valid;
  logic [INSTR_W-1:0] f_instr, id_instr;
  logic [IMEM_AW-1:0] f_idx, id_idx;
  logic               wb_valid;
  logic [2:0]         wb_op;
  logic [REG_AW-1:0]  wb_rd;
  logic [DATA_W-1:0]  wb_res;
  logic [IMEM_AW-1:0] wb_idx;

  logic               ex_valid, ex_done, ex_free;
  logic [2:0]         ex_op;
  logic [REG_AW-1:0]  ex_rd;
  logic [DATA_W-1:0]  ex_res;
  logic [IMEM_AW-1:0] ex_idx;

  logic               start_go, issue, id_take, f_take, last_retire;
  logic               wb_wr, ex_fwd_en, wb_fwd_en;
  dec_t               id_dec;

  logic [REG_AW-1:0]  src_addr [2];
  logic [DATA_W-1:0]  rf_rd    [2];
  logic [DATA_W-1:0]  opnd     [2];

  assign prog_ready = !busy_q;
  assign rf_ready   = !busy_q;
  assign start_go   = start && !busy_q;

  assign id_dec  = decode(id_instr);
  assign issue   = id_valid && ex_free;
  assign id_take = !id_valid || issue;
  assign f_take  = !f_valid || id_take;

  assign last_retire = wb_valid && ({1'b0, wb_idx} == (len_q - LEN_W'(1)));

  // Instruction memory, written only while idle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < IMEM_DEPTH; i++) imem[i] <= '0;
    end else if (prog_valid && prog_ready) begin
      imem[prog_addr] <= prog_data;
    end
  end

  // Run control, fetch and decode registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      len_q    <= '0;
      pc_q     <= '0;
      cnt_q    <= '0;
      f_valid  <= 1'b0;
      f_instr  <= '0;
      f_idx    <= '0;
      id_valid <= 1'b0;
      id_instr <= '0;
      id_idx   <= '0;
    end else if (start_go) begin
      busy_q   <= (prog_len != '0);
      done_q   <= (prog_len == '0);
      len_q    <= prog_len;
      cnt_q    <= '0;
      id_valid <= 1'b0;
      f_valid  <= (prog_len != '0);
      f_instr  <= imem[0];
      f_idx    <= '0;
      pc_q     <= LEN_W'(1);
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_retire) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (id_take) begin
        id_valid <= f_valid;
        if (f_valid) begin
          id_instr <= f_instr;
          id_idx   <= f_idx;
        end
      end
      if (f_take) begin
        if (pc_q < len_q) begin
          f_valid <= 1'b1;
          f_instr <= imem[pc_q[IMEM_AW-1:0]];
          f_idx   <= pc_q[IMEM_AW-1:0];
          pc_q    <= pc_q + 1'b1;
        end else begin
          f_valid <= 1'b0;
        end
      end
    end
  end

  // Register file with forwarding into decode.
  assign wb_wr     = wb_valid && writes_reg(wb_op);
  assign ex_fwd_en = ex_done && writes_reg(ex_op);
  assign wb_fwd_en = wb_wr;
  assign src_addr[0] = id_dec.ra;
  assign src_addr[1] = id_dec.rb;

  cpu4_regfile #(.DATA_W(DATA_W), .NRD(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_wr || (rf_valid && rf_ready)),
    .waddr (wb_wr ? wb_rd : rf_addr),
    .wdata (wb_wr ? wb_res : rf_data),
    .raddr (src_addr),
    .rdata (rf_rd)
  );

  for (genvar k = 0; k < 2; k++) begin : g_fwd
    cpu4_fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .src    (src_addr[k]),
      .rf_val (rf_rd[k]),
      .ex_en  (ex_fwd_en),
      .ex_rd  (ex_rd),
      .ex_val (ex_res),
      .wb_en  (wb_fwd_en),
      .wb_rd  (wb_rd),
      .wb_val (wb_res),
      .opnd   (opnd[k])
    );
  end

  cpu4_exec #(
    .DATA_W  (DATA_W),
    .MUL_LAT (MUL_LAT),
    .DIV_LAT (DIV_LAT),
    .IDX_W   (IMEM_AW)
  ) u_ex (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue),
    .op_i    (id_dec.op),
    .rd_i    (id_dec.rd),
    .a_i     (opnd[0]),
    .b_i     (opnd[1]),
    .idx_i   (id_idx),
    .valid_o (ex_valid),
    .done_o  (ex_done),
    .free_o  (ex_free),
    .op_o    (ex_op),
    .rd_o    (ex_rd),
    .res_o   (ex_res),
    .idx_o   (ex_idx)
  );

  // Writeback register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_op    <= '0;
      wb_rd    <= '0;
      wb_res   <= '0;
      wb_idx   <= '0;
    end else begin
      wb_valid <= ex_done;
      if (ex_done) begin
        wb_op  <= ex_op;
        wb_rd  <= ex_rd;
        wb_res <= ex_res;
        wb_idx <= ex_idx;
      end
    end
  end

  // Data array: stores land during their execute cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DM_DEPTH; i++) dmem[i] <= '0;
    end else if (ex_done && ex_op == OPC_STORE) begin
      dmem[ex_rd] <= ex_res;
    end
  end

  assign dm_data      = dmem[dm_addr];
  assign busy         = busy_q;
  assign done         = done_q;
  assign retire_valid = wb_valid;
  assign retire_idx   = wb_idx;
  assign cycle_count  = cnt_q;
endmodule

// File: rtl/cpu4_checker.sv
module cpu4_checker #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             retire_valid,
  input logic [CNT_W-1:0] cycle_count,
  input logic             prog_ready,
  input logic             rf_ready,
  input logic             ex_valid,
  input logic             ex_done,
  input logic [IDX_W-1:0] ex_idx,
  input logic             id_valid,
  input logic             issue,
  input logic [15:0]      id_instr
);
  p_retire_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> busy);

  p_ex_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && !ex_done |=> ex_valid && $stable(ex_idx));

  p_id_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !issue |=> id_valid && $stable(id_instr));

  p_done_after_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(retire_valid) || $past(start));

  p_count_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cycle_count));

  p_no_load_in_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_ready && !rf_ready);
endmodule

bind cpu4_pipe cpu4_checker #(.IDX_W($clog2(IMEM_DEPTH)), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .retire_valid (retire_valid),
  .cycle_count  (cycle_count),
  .prog_ready   (prog_ready),
  .rf_ready     (rf_ready),
  .ex_valid     (ex_valid),
  .ex_done      (ex_done),
  .ex_idx       (ex_idx),
  .id_valid     (id_valid),
  .issue        (issue),
  .id_instr     (id_instr)
);

// File: tb/tb_cpu4_pipe.sv
module tb_cpu4_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_valid = 1'b0, rf_valid = 1'b0, start = 1'b0;
  logic        prog_ready, rf_ready, busy, done, retire_valid;
  logic [3:0]  prog_addr = '0, retire_idx;
  logic [15:0] prog_data = '0, rf_data = '0, cycle_count, dm_data;
  logic [2:0]  rf_addr = '0, dm_addr = '0;
  logic [4:0]  prog_len = '0;

  int checks = 0, errors = 0;
  int rr [8];
  int dm [8];
  int prog [16];
  int nprog;
  int last_wb;

  always #2.5 clk = ~clk;

  cpu4_pipe dut (
    .clk(clk), .rst_n(rst_n),
    .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_addr(prog_addr), .prog_data(prog_data),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_addr(rf_addr), .rf_data(rf_data),
    .start(start), .prog_len(prog_len), .busy(busy), .done(done),
    .retire_valid(retire_valid), .retire_idx(retire_idx), .cycle_count(cycle_count),
    .dm_addr(dm_addr), .dm_data(dm_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int rd, input int ra, input int rb);
    return (op << 13) | (rd << 10) | (ra << 7) | (rb << 4);
  endfunction

  task automatic set_reg(input int r, input int v);
    @(negedge clk);
    rf_valid = 1'b1; rf_addr = 3'(r); rf_data = 16'(v);
    @(negedge clk);
    rf_valid = 1'b0;
    rr[r] = v & 16'hFFFF;
  endtask

  task automatic add_instr(input int w);
    @(negedge clk);
    prog_valid = 1'b1; prog_addr = 4'(nprog); prog_data = 16'(w);
    @(negedge clk);
    prog_valid = 1'b0;
    prog[nprog] = w;
    nprog++;
  endtask

  // Behavioural interpretation plus stage-cycle recurrence; poke drives a start and a preload mid-run.
  task automatic run(input bit poke);
    int ifc [16]; int idc [16]; int exs [16]; int exe [16]; int wbc [16];
    int c;
    for (int i = 0; i < nprog; i++) begin
      int op, rd, a, b, lat;
      op = (prog[i] >> 13) & 7; rd = (prog[i] >> 10) & 7;
      a = rr[(prog[i] >> 7) & 7]; b = rr[(prog[i] >> 4) & 7];
      lat = (op == 2 || op == 3) ? 3 : 1;
      case (op)
        0: rr[rd] = (a + b) & 16'hFFFF;
        1: rr[rd] = (a - b) & 16'hFFFF;
        2: rr[rd] = (a * b) & 16'hFFFF;
        3: rr[rd] = (b == 0) ? 16'hFFFF : a / b;
        4: dm[rd] = a;
        default: ;
      endcase
      ifc[i] = (i == 0) ? 1 : idc[i-1];
      idc[i] = (i == 0) ? 2 : ((ifc[i] + 1 > exs[i-1]) ? ifc[i] + 1 : exs[i-1]);
      exs[i] = (i == 0) ? 3 : ((idc[i] + 1 > exe[i-1] + 1) ? idc[i] + 1 : exe[i-1] + 1);
      exe[i] = exs[i] + lat - 1;
      wbc[i] = exe[i] + 1;
    end
    last_wb = wbc[nprog-1];
    @(negedge clk);
    prog_len = 5'(nprog); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (c <= last_wb) begin
      int exp_idx;
      exp_idx = -1;
      for (int i = 0; i < nprog; i++) if (wbc[i] == c) exp_idx = i;
      // R1 R2 R3 R10: retire strobe and index every cycle
      check(retire_valid == (exp_idx >= 0), "R2 retire timing", int'(retire_valid), int'(exp_idx >= 0));
      if (exp_idx >= 0) check(retire_idx == 4'(exp_idx), "R1 retire index", int'(retire_idx), exp_idx);
      check(cycle_count == 16'(c - 1) && !done, "R10 count while running", int'(cycle_count), c - 1);
      if (poke && c == 3) begin
        check(!prog_ready && !rf_ready, "R11 ready low in run", int'(prog_ready), 0);
        start = 1'b1; rf_valid = 1'b1; rf_addr = 3'd0; rf_data = 16'd999;
      end
      if (poke && c == 4) begin
        start = 1'b0; rf_valid = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    check(done && cycle_count == 16'(last_wb), "R10 done and final count", int'(cycle_count), last_wb);
    repeat (2) @(negedge clk);
    check(cycle_count == 16'(last_wb), "R10 count frozen", int'(cycle_count), last_wb);
    for (int a = 0; a < 8; a++) begin
      dm_addr = 3'(a);
      #1;
      check(dm_data == 16'(dm[a]), "R8 data array", int'(dm_data), dm[a]);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin rr[i] = 0; dm[i] = 0; end
    nprog = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(!done && !retire_valid && cycle_count == 0, "R12 reset outputs", int'(cycle_count), 0);
    check(prog_ready && rf_ready, "R12 idle ready", int'(prog_ready), 1);
    dm_addr = 3'd2; #1;
    check(dm_data == 0, "R12 data array clear", int'(dm_data), 0);

    // R13 R3 R5: expression program
    set_reg(0, 5); set_reg(1, 7); set_reg(2, 4); set_reg(3, 100); set_reg(4, 3);
    add_instr(enc(0, 5, 0, 1));
    add_instr(enc(2, 6, 2, 5));
    add_instr(enc(1, 5, 3, 6));
    add_instr(enc(3, 6, 5, 4));
    add_instr(enc(4, 2, 6, 0));
    run(1'b0);
    check(last_wb == 12, "R13 cycle total", last_wb, 12);
    dm_addr = 3'd2; #1;
    check(dm_data == 16'd17, "R13 result value", int'(dm_data), 17);

    // R4 R1: back-to-back single-cycle ops, distance-two dependence
    nprog = 0;
    add_instr(enc(0, 1, 0, 0));
    add_instr(enc(0, 2, 3, 3));
    add_instr(enc(0, 4, 1, 2));
    add_instr(enc(4, 5, 4, 0));
    run(1'b0);
    check(last_wb == 7, "R4 no-stall total", last_wb, 7);
    dm_addr = 3'd5; #1;
    check(dm_data == 16'd210, "R4 writeback bypass value", int'(dm_data), 210);

    // R7 R9 R5 R6: wrap, divide by zero, ignored opcode, reuse, low bits ignored
    nprog = 0;
    add_instr(enc(1, 5, 0, 3));
    add_instr(enc(2, 6, 5, 5));
    add_instr(enc(3, 1, 3, 7));
    add_instr(enc(6, 1, 0, 0) | 4'hF);
    add_instr(enc(4, 0, 1, 0));
    add_instr(enc(3, 2, 3, 4));
    add_instr(enc(2, 2, 2, 1));
    add_instr(enc(4, 1, 2, 0) | 4'h5);
    add_instr(enc(4, 3, 6, 0));
    add_instr(enc(5, 0, 0, 0));
    add_instr(enc(4, 4, 5, 0));
    run(1'b0);
    dm_addr = 3'd0; #1;
    check(dm_data == 16'hFFFF, "R7 divide by zero and R9 no write", int'(dm_data), 65535);

    // R10 R11: start and preload offered mid-run are dropped
    run(1'b1);
    set_reg(7, 9);
    nprog = 0;
    add_instr(enc(0, 6, 0, 7));
    add_instr(enc(4, 7, 6, 0));
    run(1'b0);
    dm_addr = 3'd7; #1;
    check(dm_data == 16'd14, "R11 dropped preload left R0", int'(dm_data), 14);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule